// File: doc/BRIEF.md
# Receive Word Queue with Idle Timeout

This block sits behind a serial receiver and holds received words in a small first-in first-out store until a host reads them. The receiver delivers each finished word with a one-cycle write strobe. The host pulls words out with a one-cycle read strobe, and the word appears on the read data output one cycle later. Empty and full flags tell both sides what they may do next.

An idle detector watches the queue. Whenever words are waiting and no new word has arrived for a set number of serial clock periods, it raises a raw timeout status. A host can then drain a short tail of a message without waiting for a threshold to be reached. The serial clock is supplied as a one-cycle tick per period. A single clear input acknowledges both the timeout status and a sticky overrun bit, which records words lost because the queue was full.

Top module: `rx_fifo_tmo`

## Requirements
- R1: After reset the queue is empty (`empty`=1, `full`=0), and `tmo_flag`, `ovr_flag` and `rd_data` are all 0.
- R2: Words come out in the order they were accepted. A read strobe while not empty places the oldest word on `rd_data` on the following clock edge.
- R3: The queue holds DEPTH words (default 8). `full` is 1 exactly when DEPTH words are held, `empty` is 1 exactly when none are held, and the two are never 1 together.
- R4: A write strobe while `full` is 1 stores nothing and sets `ovr_flag`. The flag stays set until a cycle with `clr` high and no dropped write. A dropped write in the same cycle as `clr` leaves the flag set.
- R5: A read strobe while `empty` is 1 leaves `rd_data` and the queue contents unchanged.
- R6: While words are held and none is accepted, `tmo_flag` rises on the clock edge that ends the TMO_TICKS-th tick (default 32) counted since the last accepted write, clear, or transition from empty.
- R7: Every accepted write restarts the idle count at its full period. A write dropped because the queue is full does not restart it.
- R8: `tmo_flag` falls on the clock edge after a cycle with `clr` high, or on the edge at which the queue becomes empty. It is never 1 while `empty` is 1.
- R9: After a clear that leaves words in the queue, `tmo_flag` rises again after another full TMO_TICKS ticks. Ticks while the queue is empty are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe from the serial receiver |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read strobe from the host |
| rd_data | output | DATA_W | Word last read out |
| tick | input | 1 | One pulse per serial clock period |
| clr | input | 1 | Write-one clear of timeout and overrun status |
| empty | output | 1 | Queue holds no words |
| full | output | 1 | Queue holds DEPTH words |
| tmo_flag | output | 1 | Raw idle timeout status |
| ovr_flag | output | 1 | Sticky overrun status |

## Verification
The bench counts ticks precisely across the timeout boundary, so an off-by-one counter would show the flag one tick early or one tick late. It restarts the count with a write part-way through the period, which exposes a design that arms the count only on the transition from empty. It clears the status while words remain, which exposes a design that never raises the flag a second time. It writes into a full queue, which exposes designs that overwrite a held word or restart the count on the dropped word. It reads from an empty queue, where a broken pointer guard would corrupt the output or the word order.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   // per-cycle handshake outcome shared by storage and timer
   typedef struct packed {
      logic wr_acc;   // write accepted this cycle
      logic rd_acc;   // read accepted this cycle
      logic drained;  // queue will be empty after this edge
   } rxq_ctl_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
   import rxq_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty,
   output logic              full,
   output rxq_ctl_t          ctl
);
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned LW = $clog2(DEPTH + 1);
   localparam bit          POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PW-1:0]     wptr, rptr, wptr_inc, rptr_inc;
   logic [LW-1:0]     level, level_nxt;
   logic              wacc, racc;

   assign empty = (level == '0);
   assign full  = (level == LW'(DEPTH));
   assign wacc  = wr_en && !full;
   assign racc  = rd_en && !empty;
   assign level_nxt = level + LW'(wacc) - LW'(racc);

   assign ctl.wr_acc  = wacc;
   assign ctl.rd_acc  = racc;
   assign ctl.drained = (level_nxt == '0);

   generate
      if (POW2) begin : g_wrap_nat
         assign wptr_inc = wptr + PW'(1);
         assign rptr_inc = rptr + PW'(1);
      end else begin : g_wrap_cmp
         assign wptr_inc = (wptr == PW'(DEPTH - 1)) ? '0 : wptr + PW'(1);
         assign rptr_inc = (rptr == PW'(DEPTH - 1)) ? '0 : rptr + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr    <= '0;
         rptr    <= '0;
         level   <= '0;
         rd_data <= '0;
      end else begin
         level <= level_nxt;
         if (wacc) wptr <= wptr_inc;
         if (racc) begin
            rptr    <= rptr_inc;
            rd_data <= mem[rptr];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wacc) mem[wptr] <= wr_data;
   end
endmodule

// File: rtl/rxq_timer.sv
module rxq_timer
   import rxq_pkg::*;
#(
   parameter int unsigned TMO_TICKS = 32
) (
   input  logic     clk,
   input  logic     rst_n,
   input  rxq_ctl_t ctl,
   input  logic     tick,
   input  logic     clr,
   output logic     tmo
);
   localparam int unsigned CW = $clog2(TMO_TICKS + 1);
   localparam logic [CW-1:0] LOAD = CW'(TMO_TICKS);

   logic [CW-1:0] cnt;
   logic          restart, expire;

   assign restart = ctl.wr_acc || ctl.drained || clr;
   assign expire  = !restart && tick && (cnt == CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= LOAD;
         tmo <= 1'b0;
      end else begin
         if (restart)                 cnt <= LOAD;
         else if (tick && cnt != '0)  cnt <= cnt - CW'(1);
         if (ctl.drained || clr)      tmo <= 1'b0;
         else if (expire)             tmo <= 1'b1;
      end
   end
endmodule

// File: rtl/rx_fifo_tmo.sv
module rx_fifo_tmo
   import rxq_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned DEPTH     = 8,
   parameter int unsigned TMO_TICKS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   input  logic              tick,
   input  logic              clr,
   output logic              empty,
   output logic              full,
   output logic              tmo_flag,
   output logic              ovr_flag
);
   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("rx_fifo_tmo: DATA_W must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_d
         $error("rx_fifo_tmo: DEPTH must be at least 2");
      end
      if (TMO_TICKS < 1) begin : g_bad_t
         $error("rx_fifo_tmo: TMO_TICKS must be at least 1");
      end
   endgenerate

   rxq_ctl_t ctl;

   rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .rd_data (rd_data),
      .empty   (empty),
      .full    (full),
      .ctl     (ctl)
   );

   rxq_timer #(.TMO_TICKS(TMO_TICKS)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .ctl   (ctl),
      .tick  (tick),
      .clr   (clr),
      .tmo   (tmo_flag)
   );

   // sticky overrun: a dropped word outranks a clear in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n)             ovr_flag <= 1'b0;
      else if (wr_en && full) ovr_flag <= 1'b1;
      else if (clr)           ovr_flag <= 1'b0;
   end
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic              tick,
   input logic              clr,
   input logic              empty,
   input logic              full,
   input logic              tmo_flag,
   input logic              ovr_flag,
   input logic [DATA_W-1:0] rd_data
);
   p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(empty && full));

   p_empty_read_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && empty) |=> $stable(rd_data));

   p_ovr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full) |=> ovr_flag);

   p_ovr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_flag && !clr) |=> ovr_flag);

   p_no_tmo_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !tmo_flag);

   p_clr_drops_tmo_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !tmo_flag);

   p_tmo_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_flag) |-> ($past(tick) && !$past(clr)));
endmodule

bind rx_fifo_tmo rxq_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_rx_fifo_tmo.sv
module tb_rx_fifo_tmo;
   localparam int DW = 8;
   localparam int DP = 8;
   localparam int TT = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0, clr = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          empty, full, tmo_flag, ovr_flag;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // reference state
   logic [DW-1:0] q[$];
   logic [DW-1:0] m_rd = '0;
   int            m_cnt = TT;
   bit            m_tmo = 0, m_ovr = 0;

   always #2.5 clk = ~clk;

   rx_fifo_tmo #(.DATA_W(DW), .DEPTH(DP), .TMO_TICKS(TT)) dut (.*);

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   // next-state of the reference, from the requirements
   function automatic void model_step(bit w, logic [DW-1:0] d, bit r, bit t, bit c);
      bit was_full = (q.size() == DP);
      bit wa = w && !was_full;
      bit ra = r && (q.size() != 0);
      bit drn;
      if (ra) m_rd = q.pop_front();          // R2, R5
      if (wa) q.push_back(d);
      drn = (q.size() == 0);
      if (w && was_full) m_ovr = 1;          // R4
      else if (c) m_ovr = 0;
      if (drn || c) m_tmo = 0;               // R8
      else if (!wa && t && m_cnt == 1) m_tmo = 1;  // R6
      if (wa || drn || c) m_cnt = TT;        // R7, R9
      else if (t && m_cnt != 0) m_cnt--;
   endfunction

   task automatic compare_all();
      chk("R2 rd_data", rd_data, m_rd);
      chk("R3 empty", empty, q.size() == 0);
      chk("R3 full", full, q.size() == DP);
      chk("R4 ovr_flag", ovr_flag, m_ovr);
      chk("R6 tmo_flag", tmo_flag, m_tmo);
   endtask

   task automatic step(bit w, logic [DW-1:0] d, bit r, bit t, bit c);
      wr_en = w; wr_data = d; rd_en = r; tick = t; clr = c;
      @(posedge clk);
      model_step(w, d, r, t, c);
      @(negedge clk);
      wr_en = 0; rd_en = 0; tick = 0; clr = 0;
      compare_all();
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) step(0, '0, 0, 1, 0);
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 empty", empty, 1);
      chk("R1 full", full, 0);
      chk("R1 tmo", tmo_flag, 0);
      chk("R1 ovr", ovr_flag, 0);
      chk("R1 rd_data", rd_data, 0);

      // R9 ticks while empty do nothing
      ticks(40);
      chk("R9 no tmo while empty", tmo_flag, 0);

      // R6 exact boundary
      step(1, 8'hA1, 0, 0, 0);
      ticks(TT - 1);
      chk("R6 not yet at 31", tmo_flag, 0);
      ticks(1);
      chk("R6 set at 32", tmo_flag, 1);

      // R9 clear with residual data, then another full period
      step(0, '0, 0, 0, 1);
      chk("R8 cleared by clr", tmo_flag, 0);
      ticks(TT - 1);
      chk("R9 not yet", tmo_flag, 0);
      ticks(1);
      chk("R9 set again", tmo_flag, 1);
      step(0, '0, 0, 0, 1);

      // R7 write mid-period restarts the count
      ticks(20);
      step(1, 8'hA2, 0, 0, 0);
      ticks(TT - 1);
      chk("R7 reload holds off", tmo_flag, 0);
      ticks(1);
      chk("R7 set after reload", tmo_flag, 1);

      // R8 draining clears the flag
      step(0, '0, 1, 0, 0);
      chk("R2 first out", rd_data, 8'hA1);
      step(0, '0, 1, 0, 0);
      chk("R2 second out", rd_data, 8'hA2);
      chk("R8 drained clears", tmo_flag, 0);

      // R5 read while empty
      step(0, '0, 1, 0, 0);
      chk("R5 empty read holds", rd_data, 8'hA2);
      chk("R5 still empty", empty, 1);

      // R3/R4 fill, overrun, dropped write no reload (R7)
      for (int i = 0; i < DP; i++) step(1, DW'(8'h10 + i), 0, 0, 0);
      chk("R3 full at depth", full, 1);
      ticks(TT - 1);
      step(1, 8'hEE, 0, 0, 0);
      chk("R4 ovr set", ovr_flag, 1);
      ticks(1);
      chk("R7 dropped write no reload", tmo_flag, 1);
      step(1, 8'hEF, 0, 0, 1);
      chk("R4 set beats clr", ovr_flag, 1);
      step(0, '0, 0, 0, 1);
      chk("R4 clr resets ovr", ovr_flag, 0);
      for (int i = 0; i < DP; i++) begin
         step(0, '0, 1, 0, 0);
         chk("R2 order after fill", rd_data, 8'h10 + i);
      end
      chk("R4 overrun word not stored", empty, 1);

      // random phases: busy and sparse writers
      for (int i = 0; i < 3000; i++)
         step(($urandom % 10) < 4, DW'($urandom), ($urandom % 10) < 3,
              ($urandom % 2) == 1, ($urandom % 40) == 0);
      for (int i = 0; i < 4000; i++)
         step(($urandom % 60) == 0, DW'($urandom), ($urandom % 80) == 0,
              ($urandom % 3) != 0, ($urandom % 150) == 0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule